// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Front End

This block sits in front of a small processor core and turns five hardware request lines into a single request flag and a 16-bit service address. One line cannot be masked and always gets through. Three lines each have a fixed service address and their own mask bit. One general line only raises the flag, and the core fetches its vector by other means. A global enable flip-flop gates every line except the non-maskable one.

Software controls the unit through a one-byte mask write and reads it back through a one-byte status word. The mask write can also clear the latched edge of the top vectored line and load a serial output bit. Separate pulses set and clear the enable flip-flop. When the core takes an interrupt it pulses `irq_ack`. If the source taken is maskable, the unit clears the enable flip-flop. If that source is the edge-triggered line, the unit also clears that line's edge latch.

Top module: `irq_front`

## Requirements
- R1: While `nmi_req` is 1, `irq_valid` is 1, `irq_vector` is 0024h and `irq_ext` is 0, whatever the enable flag and masks hold.
- R2: Reset clears the enable flag. An `ie_set` pulse sets it from the next cycle on, and an `ie_clr` pulse clears it. If both are asserted, clear wins. The flag is shown in status bit 3.
- R3: While the enable flag is 0, no input other than `nmi_req` asserts `irq_valid`.
- R4: Without `nmi_req`, the unmasked pending input that is served is chosen by fixed priority: high (vector 003Ch), then mid (0034h), then low (002Ch), then general. The general input gives `irq_ext`=1 and vector 0000h.
- R5: In a mask write, bits 0, 1 and 2 mask the low, mid and high inputs, where 1 means masked. They are loaded only when bit 3 of the byte is 1. Reset sets all three masks.
- R6: A masked input never asserts `irq_valid`, but its pending flag remains visible in the status byte.
- R7: A 0-to-1 transition on `vec_hi_req` sets the high pending latch, and the latch stays set after the input drops. Holding the input high does not set the latch again. The latch is cleared by acknowledging the high source or by a mask write with bit 4 set. A new edge wins over a clear in the same cycle.
- R8: Acknowledging a maskable source clears the enable flag. Acknowledging while `nmi_req` is 1 leaves the flag unchanged.
- R9: A mask write with bit 6 set loads bit 7 into `ser_out`. Otherwise `ser_out` holds its value, and it resets to 0.
- R10: The status byte holds the masks in bits 2:0, the enable flag in bit 3, the pending flags for low, mid and high in bits 4, 5 and 6, and `ser_in` in bit 7. The low and mid pending flags follow their inputs' levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, level |
| vec_hi_req | input | 1 | High vectored request, rising edge |
| vec_mid_req | input | 1 | Mid vectored request, level |
| vec_lo_req | input | 1 | Low vectored request, level |
| gen_req | input | 1 | General request, level, not vectored |
| ie_set | input | 1 | Set enable flag |
| ie_clr | input | 1 | Clear enable flag |
| msk_wr | input | 1 | Mask write strobe |
| msk_wdata | input | 8 | Mask write byte |
| irq_ack | input | 1 | Core takes the presented interrupt |
| ser_in | input | 1 | Serial input bit |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Service address of the selected source |
| irq_ext | output | 1 | Selected source is the general line |
| status | output | 8 | Status byte |
| ser_out | output | 1 | Serial output bit |

## Verification
On every cycle, the assertions check several properties. The non-maskable line always wins. A cleared enable flag silences every other line. An acknowledge of a maskable source drops the enable flag. The masks and the serial bit change only on a qualifying write. A served high vector never has its mask set. The high latch holds until it is acknowledged or cleared. The bench's scenarios show the rest. These are the exact priority order among simultaneous sources, the single-edge behaviour of the latch when its input is held high, a mask write with bit 3 clear being ignored, and the status layout under random traffic.

// File: rtl/irq_front.sv
module irq_front #(
  parameter logic [15:0] NMI_VEC = 16'h0024,
  parameter logic [15:0] HI_VEC  = 16'h003C,
  parameter logic [15:0] MID_VEC = 16'h0034,
  parameter logic [15:0] LO_VEC  = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        vec_hi_req,
  input  logic        vec_mid_req,
  input  logic        vec_lo_req,
  input  logic        gen_req,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        msk_wr,
  input  logic [7:0]  msk_wdata,
  input  logic        irq_ack,
  input  logic        ser_in,
  output logic        irq_valid,
  output logic [15:0] irq_vector,
  output logic        irq_ext,
  output logic [7:0]  status,
  output logic        ser_out
);
  logic       ie, hi_lat, hi_prev;
  logic [2:0] msk;

  wire       hi_edge  = vec_hi_req & ~hi_prev;
  wire [2:0] pend     = {hi_lat, vec_mid_req, vec_lo_req};
  wire [2:0] live     = pend & ~msk & {3{ie}};
  wire       gen_live = ie & gen_req;
  wire       mask_any = (|live) | gen_live;
  wire       take_msk = irq_ack & ~nmi_req & mask_any;
  wire       take_hi  = irq_ack & ~nmi_req & live[2];
  wire       wr_msk   = msk_wr & msk_wdata[3];
  wire       wr_clr   = msk_wr & msk_wdata[4];
  wire       wr_ser   = msk_wr & msk_wdata[6];

  assign irq_valid = nmi_req | mask_any;
  assign status    = {ser_in, pend, ie, msk};

  always_comb begin
    irq_vector = 16'h0000;
    irq_ext    = 1'b0;
    if (nmi_req)       irq_vector = NMI_VEC;
    else if (live[2])  irq_vector = HI_VEC;
    else if (live[1])  irq_vector = MID_VEC;
    else if (live[0])  irq_vector = LO_VEC;
    else if (gen_live) irq_ext    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      msk     <= 3'b111;
      hi_lat  <= 1'b0;
      hi_prev <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      hi_prev <= vec_hi_req;
      if (take_msk || ie_clr) ie <= 1'b0;
      else if (ie_set)        ie <= 1'b1;
      if (wr_msk) msk <= msk_wdata[2:0];
      if (hi_edge)                hi_lat <= 1'b1;
      else if (take_hi || wr_clr) hi_lat <= 1'b0;
      if (wr_ser) ser_out <= msk_wdata[7];
    end
  end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_req,
  input logic        irq_ack,
  input logic        msk_wr,
  input logic [7:0]  msk_wdata,
  input logic        irq_valid,
  input logic [15:0] irq_vector,
  input logic        irq_ext,
  input logic [7:0]  status,
  input logic        ser_out
);
  p_nmi_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> irq_valid && irq_vector == 16'h0024 && !irq_ext);

  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[3] && !nmi_req) |-> !irq_valid);

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(msk_wr && msk_wdata[3]) |=> $stable(status[2:0]));

  p_hi_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !nmi_req && irq_vector == 16'h003C) |-> (!status[2] && status[6]));

  p_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !irq_ack && !(msk_wr && msk_wdata[4])) |=> status[6]);

  p_take_clears_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !nmi_req) |=> !status[3]);

  p_ser_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(msk_wr && msk_wdata[6]) |=> $stable(ser_out));
endmodule

bind irq_front irq_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_ack(irq_ack),
  .msk_wr(msk_wr), .msk_wdata(msk_wdata), .irq_valid(irq_valid),
  .irq_vector(irq_vector), .irq_ext(irq_ext), .status(status),
  .ser_out(ser_out)
);

// File: tb/irq_front_test.sv
module irq_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, hi = 0, mid = 0, lo = 0, gen = 0, iset = 0, iclr = 0;
  logic wr = 0, ack = 0, sin = 0;
  logic [7:0] wdat = 8'h00;
  logic irq_valid, irq_ext, ser_out;
  logic [15:0] irq_vector;
  logic [7:0] status;

  int checks = 0, fails = 0;
  logic m_ie, m_lat, m_prev, m_ser;
  logic [2:0] m_msk;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_front uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi), .vec_hi_req(hi),
    .vec_mid_req(mid), .vec_lo_req(lo), .gen_req(gen), .ie_set(iset),
    .ie_clr(iclr), .msk_wr(wr), .msk_wdata(wdat), .irq_ack(ack),
    .ser_in(sin), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_ext(irq_ext), .status(status), .ser_out(ser_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] live_f();
    return {m_lat, mid, lo} & ~m_msk & {3{m_ie}};
  endfunction

  function automatic logic [15:0] exp_vec();
    logic [2:0] l = live_f();
    if (nmi) return 16'h0024;
    if (l[2]) return 16'h003C;
    if (l[1]) return 16'h0034;
    if (l[0]) return 16'h002C;
    return 16'h0000;
  endfunction

  task automatic cyc(input string tag);
    logic [2:0] l;
    logic gl, tm, th;
    #1;
    l  = live_f();
    gl = m_ie & gen;
    chk({tag, " valid"}, irq_valid, nmi | (|l) | gl);
    chk({tag, " vector"}, irq_vector, exp_vec());
    chk({tag, " ext"}, irq_ext, !nmi && l == 3'b000 && gl);
    chk("R10 status", status, {sin, m_lat, mid, lo, m_ie, m_msk});
    chk("R9 ser_out", ser_out, m_ser);
    tm = ack & !nmi & ((|l) | gl);
    th = ack & !nmi & l[2];
    if (tm || iclr) m_ie = 1'b0; else if (iset) m_ie = 1'b1;
    if (wr && wdat[3]) m_msk = wdat[2:0];
    if (hi && !m_prev) m_lat = 1'b1;
    else if (th || (wr && wdat[4])) m_lat = 1'b0;
    if (wr && wdat[6]) m_ser = wdat[7];
    m_prev = hi;
    @(negedge clk);
    {iset, iclr, wr, ack} = 4'b0;
  endtask

  task automatic mwrite(input logic [7:0] d, input string tag);
    wr = 1'b1; wdat = d; cyc(tag);
  endtask

  initial begin
    m_ie = 0; m_lat = 0; m_prev = 0; m_ser = 0; m_msk = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 reset status", status, 8'h07);
    chk("R5 reset masks", status[2:0], 3'b111);
    cyc("R2");
    nmi = 1; cyc("R1"); nmi = 0;
    gen = 1; cyc("R3");
    iset = 1; cyc("R2");
    cyc("R4 general");
    ack = 1; cyc("R8");
    cyc("R3 after take"); gen = 0;
    mwrite(8'h08, "R5 unmask");
    chk("R5 masks cleared", status[2:0], 3'b000);
    iset = 1; lo = 1; mid = 1; cyc("R4 mid over low");
    hi = 1; cyc("R7 edge");
    cyc("R4 hi first");
    hi = 0; cyc("R7 latch holds");
    chk("R7 latch visible", status[6], 1'b1);
    mwrite(8'h10, "R7 clear");
    chk("R7 cleared", status[6], 1'b0);
    hi = 1; cyc("R7 edge2"); mwrite(8'h10, "R7 clr held");
    cyc("R7 no re-edge");
    chk("R7 held high no set", status[6], 1'b0);
    hi = 0;
    mwrite(8'h07, "R5 ignored");
    chk("R5 no bit3", status[2:0], 3'b000);
    mwrite(8'h0A, "R6 mask mid"); lo = 0;
    cyc("R6");
    chk("R6 masked no req", irq_valid, 1'b0);
    chk("R6 pending seen", status[5], 1'b1);
    mwrite(8'hC0, "R9 load one");
    chk("R9 ser high", ser_out, 1'b1);
    mwrite(8'h80, "R9 no enable");
    mwrite(8'h40, "R9 load zero");
    nmi = 1; ack = 1; cyc("R8 nmi ack");
    chk("R8 ie kept", status[3], 1'b1);
    nmi = 0; iset = 1; iclr = 1; cyc("R2 both");
    sin = 1; cyc("R10 serial in");
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      nmi  = ($urandom % 16) == 0;
      hi   = $urandom % 2; mid = $urandom % 2; lo = $urandom % 2;
      gen  = $urandom % 2; sin = $urandom % 2;
      iset = ($urandom % 3) == 0; iclr = ($urandom % 8) == 0;
      ack  = ($urandom % 4) == 0; wr = ($urandom % 5) == 0;
      wdat = 8'($urandom);
      cyc("R4 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule